// File: doc/BRIEF.md
# PoE PSE Port Sequencer

This block is the control state machine for a single Power over Ethernet power-sourcing port. An operating mode code sets the power budget, the midspan or endpoint retry period, the restart policy after a fault, and whether classification runs. The block captures this code at reset release. It then steps the port through a three-level signature probe, then one- or two-event classification, then gated power-up and steady powering. After an error, fault or disconnect it waits for a set time and then probes again.

All timing counts whole milliseconds on a one-cycle `ms_tick` strobe. Analog measurement is done outside the block and arrives as flags: signature good, open circuit, class code, supply limits, overload fault and load-gone pulses. The outputs drive the probe voltage selector, the classification and mark enables, the pass-gate enable and an LED pattern code.

Top module: `pse_port_seq`

## Requirements
- R1: While `rst` is high, `gate_en`, `cls_en` and `mark_en` are 0 and `probe_sel` and `led_code` are 0. On the first clock edge after release, the probe starts at the low level.
- R2: A probe round drives `probe_sel` to 1 (low level, 4 V) for `DET_LO1_MS` ticks, then to 2 (high level, 8 V) for `DET_HI_MS` ticks, then to 1 for `DET_LO2_MS` ticks. `sig_good` is sampled on the tick that ends the round.
- R3: When the signature is bad, the probe stops (`probe_sel`=0, `led_code`=1 slow blink). A new round starts after `GAP_END_MS` ticks in endpoint mode and after `GAP_MID_MS` ticks in midspan mode.
- R4: In the full-budget classify mode a good signature starts a two-event sequence: `cls_en` for `CLS_MS`, `mark_en` for `MARK_MS`, then `cls_en` for `CLS_MS`. If `class_code` is 4 at the end, power-up starts (`gate_en`=1, `led_code`=2 steady).
- R5: If the two-event result is not 4, or the budget is below full, one single `CLS_MS` pulse runs without a mark. A class that fits the budget at its end grants power.
- R6: A class that does not fit the budget causes denial. Full allows 0..4, mid allows 0..3, low allows only 1 and 2, and codes 5..7 are always denied. Denial gives `led_code`=3 (fast blink) with the gate off for `DENY_MS` ticks, and then a new probe round in either restart policy.
- R7: During the first `PWRUP_MS` ticks of power-up a `disc_pulse` is ignored and the gate stays on.
- R8: A `fault_pulse` during power-up or powering turns the gate off on the next edge with fast blink. In auto-restart mode probing resumes after `RESTART_MS` ticks.
- R9: In latch-off mode the fault blink continues past `RESTART_MS` until `open_ok` is seen. Probing starts on the next edge after that.
- R10: A `disc_pulse` while powering turns the gate off with `led_code`=0. Probing resumes after `DISC_MS` ticks.
- R11: `uv_flag` or `ov_flag` in any state sends the block to the error state with the gate off on the next edge. The error timer is held at zero while either flag stays high. On expiry the fault restart policy applies.
- R12: No-classify modes go from a good signature straight to power-up with no classification or mark pulse.
- R13: `mode_cfg` is sampled only while `rst` is high; later changes have no effect. Mode bit 3 = endpoint, bit 2 = auto-restart. Bits 1:0 select: 00 full budget without classification, 01 low budget with classification, 10 mid budget without classification, 11 full budget with classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the mode capture window |
| mode_cfg | input | 4 | Operating mode code (see R13) |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| sig_good | input | 1 | Signature resistance in the good range |
| open_ok | input | 1 | Open circuit sensed on the port |
| class_code | input | 3 | Measured class at the end of a classification pulse |
| uv_flag | input | 1 | Supply below lower limit |
| ov_flag | input | 1 | Supply above upper limit |
| fault_pulse | input | 1 | Overload fault from the current monitor |
| disc_pulse | input | 1 | Load-removed event from the current monitor |
| probe_sel | output | 2 | Probe level: 0 none, 1 low, 2 high |
| cls_en | output | 1 | Classification voltage enable |
| mark_en | output | 1 | Mark voltage enable |
| gate_en | output | 1 | Pass gate enable |
| led_code | output | 2 | LED pattern: 0 off, 1 slow, 2 steady, 3 fast |

## Verification
The assertions assume that the monitor pulses are one cycle wide. They also assume that `ms_tick` never lasts longer than one cycle, and that `class_code` and `sig_good` are stable around the tick that ends a phase. The bench drives every input on the falling edge and produces the tick as a single-cycle strobe every third clock. It changes the class and signature flags only in the falling-edge slot well before the ending tick, and it sends fault and load-removed events as single-cycle pulses. This keeps the stimulus inside those assumptions.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;

    typedef enum logic [1:0] {
        BUD_LOW  = 2'd0,
        BUD_MID  = 2'd1,
        BUD_FULL = 2'd2
    } budget_e;

    typedef enum logic [1:0] {
        LED_OFF    = 2'd0,
        LED_SLOW   = 2'd1,
        LED_STEADY = 2'd2,
        LED_FAST   = 2'd3
    } led_e;

    typedef enum logic [1:0] {
        PROBE_NONE = 2'd0,
        PROBE_LOW  = 2'd1,
        PROBE_HIGH = 2'd2
    } probe_e;

    typedef enum logic [3:0] {
        ST_OFF, ST_DET_LO1, ST_DET_HI, ST_DET_LO2, ST_DET_GAP,
        ST_CLS_A, ST_MARK, ST_CLS_B, ST_CLS_ONE,
        ST_PWRUP, ST_POWERED, ST_ERROR, ST_WAIT_OPEN, ST_DISC
    } seq_state_e;

    typedef struct packed {
        logic    endpoint;
        logic    auto_restart;
        logic    classify;
        budget_e budget;
    } port_cfg_t;

    function automatic port_cfg_t decode_cfg(input logic [3:0] code);
        port_cfg_t c;
        c.endpoint     = code[3];
        c.auto_restart = code[2];
        c.classify     = code[0];
        case (code[1:0])
            2'b01:   c.budget = BUD_LOW;
            2'b10:   c.budget = BUD_MID;
            default: c.budget = BUD_FULL;
        endcase
        return c;
    endfunction

    function automatic logic class_fits(input logic [2:0] cls, input budget_e b);
        if (cls > 3'd4) return 1'b0;
        case (b)
            BUD_FULL: return 1'b1;
            BUD_MID:  return cls <= 3'd3;
            default:  return (cls == 3'd1) || (cls == 3'd2);
        endcase
    endfunction

endpackage

// File: rtl/pse_cfg_latch.sv
module pse_cfg_latch
    import pse_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_cfg,
    output port_cfg_t  cfg
);
    port_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= decode_cfg(mode_cfg);
    end

    assign cfg = cfg_q;

    p_cfg_frozen_r13: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_q));
endmodule

// File: rtl/pse_ms_timer.sv
module pse_ms_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    output logic [TW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)                cnt <= '0;
        else if (tick && (cnt != '1))  cnt <= cnt + 1'b1;
    end

    p_cnt_from_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (cnt == '0));
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
    import pse_seq_pkg::*;
#(
    parameter int DET_LO1_MS = 20,
    parameter int DET_HI_MS  = 20,
    parameter int DET_LO2_MS = 50,
    parameter int GAP_END_MS = 310,
    parameter int GAP_MID_MS = 2110,
    parameter int CLS_MS     = 30,
    parameter int MARK_MS    = 10,
    parameter int PWRUP_MS   = 75,
    parameter int DENY_MS    = 2000,
    parameter int RESTART_MS = 2200,
    parameter int DISC_MS    = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode_cfg,
    input  logic       ms_tick,
    input  logic       sig_good,
    input  logic       open_ok,
    input  logic [2:0] class_code,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       fault_pulse,
    input  logic       disc_pulse,
    output logic [1:0] probe_sel,
    output logic       cls_en,
    output logic       mark_en,
    output logic       gate_en,
    output logic [1:0] led_code
);
    localparam int LIM_SUM = DET_LO1_MS + DET_HI_MS + DET_LO2_MS + GAP_END_MS + GAP_MID_MS
                           + CLS_MS + MARK_MS + PWRUP_MS + DENY_MS + RESTART_MS + DISC_MS;
    localparam int TW = $clog2(LIM_SUM + 1);

    port_cfg_t       cfg;
    seq_state_e      st, nxt;
    logic [TW-1:0]   cnt, lim;
    logic            expired, supply_bad, err_deny, clr;

    pse_cfg_latch u_cfg (.clk(clk), .rst(rst), .mode_cfg(mode_cfg), .cfg(cfg));

    assign supply_bad = uv_flag || ov_flag;
    assign clr        = (nxt != st) || supply_bad;

    pse_ms_timer #(.TW(TW)) u_tmr (.clk(clk), .rst(rst), .clr(clr), .tick(ms_tick), .cnt(cnt));

    always_comb begin
        case (st)
            ST_DET_LO1: lim = TW'(DET_LO1_MS);
            ST_DET_HI:  lim = TW'(DET_HI_MS);
            ST_DET_LO2: lim = TW'(DET_LO2_MS);
            ST_DET_GAP: lim = cfg.endpoint ? TW'(GAP_END_MS) : TW'(GAP_MID_MS);
            ST_CLS_A, ST_CLS_B, ST_CLS_ONE: lim = TW'(CLS_MS);
            ST_MARK:    lim = TW'(MARK_MS);
            ST_PWRUP:   lim = TW'(PWRUP_MS);
            ST_ERROR:   lim = err_deny ? TW'(DENY_MS) : TW'(RESTART_MS);
            ST_DISC:    lim = TW'(DISC_MS);
            default:    lim = '0;
        endcase
    end

    assign expired = ms_tick && (cnt == (lim - TW'(1)));

    always_comb begin
        nxt = st;
        if (supply_bad) begin
            nxt = ST_ERROR;
        end else begin
            case (st)
                ST_OFF:     nxt = ST_DET_LO1;
                ST_DET_LO1: if (expired) nxt = ST_DET_HI;
                ST_DET_HI:  if (expired) nxt = ST_DET_LO2;
                ST_DET_LO2: if (expired) begin
                    if (!sig_good)                        nxt = ST_DET_GAP;
                    else if (!cfg.classify)               nxt = ST_PWRUP;
                    else if (cfg.budget == BUD_FULL)      nxt = ST_CLS_A;
                    else                                  nxt = ST_CLS_ONE;
                end
                ST_DET_GAP: if (expired) nxt = ST_DET_LO1;
                ST_CLS_A:   if (expired) nxt = ST_MARK;
                ST_MARK:    if (expired) nxt = ST_CLS_B;
                ST_CLS_B:   if (expired) nxt = (class_code == 3'd4) ? ST_PWRUP : ST_CLS_ONE;
                ST_CLS_ONE: if (expired)
                    nxt = class_fits(class_code, cfg.budget) ? ST_PWRUP : ST_ERROR;
                ST_PWRUP: begin
                    if (fault_pulse)  nxt = ST_ERROR;
                    else if (expired) nxt = ST_POWERED;
                end
                ST_POWERED: begin
                    if (fault_pulse)     nxt = ST_ERROR;
                    else if (disc_pulse) nxt = ST_DISC;
                end
                ST_ERROR: if (expired)
                    nxt = (err_deny || cfg.auto_restart) ? ST_DET_LO1 : ST_WAIT_OPEN;
                ST_WAIT_OPEN: if (open_ok) nxt = ST_DET_LO1;
                ST_DISC:    if (expired) nxt = ST_DET_LO1;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            err_deny <= 1'b0;
        end else begin
            st <= nxt;
            if (supply_bad)
                err_deny <= 1'b0;
            else if (nxt == ST_ERROR && st != ST_ERROR)
                err_deny <= (st == ST_CLS_ONE);
        end
    end

    always_comb begin
        probe_sel = PROBE_NONE;
        cls_en    = 1'b0;
        mark_en   = 1'b0;
        gate_en   = 1'b0;
        led_code  = LED_OFF;
        case (st)
            ST_DET_LO1, ST_DET_LO2: begin probe_sel = PROBE_LOW;  led_code = LED_SLOW; end
            ST_DET_HI:              begin probe_sel = PROBE_HIGH; led_code = LED_SLOW; end
            ST_DET_GAP:             led_code = LED_SLOW;
            ST_CLS_A, ST_CLS_B, ST_CLS_ONE: begin cls_en = 1'b1; led_code = LED_SLOW; end
            ST_MARK:                begin mark_en = 1'b1; led_code = LED_SLOW; end
            ST_PWRUP, ST_POWERED:   begin gate_en = 1'b1; led_code = LED_STEADY; end
            ST_ERROR, ST_WAIT_OPEN: led_code = LED_FAST;
            default: ;
        endcase
    end

    p_supply_gate_off_r11: assert property (@(posedge clk) disable iff (rst)
        supply_bad |=> !gate_en);
    p_mark_follows_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_en) |-> $past(cls_en));
    p_gate_after_probe_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_en) |-> $past((probe_sel == PROBE_LOW) || cls_en));
    p_quiet_when_powered_r7: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (probe_sel == PROBE_NONE) && !cls_en && !mark_en);
    p_fault_drops_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_pulse && gate_en) |=> !gate_en);
endmodule

// File: tb/pse_port_seq_tb_top.sv
module pse_port_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int D1 = 4, DH = 4, D2 = 6, GEP = 5, GMS = 12;
    localparam int CLS = 5, MRK = 3, PWR = 4, DNY = 8, RST_MS = 10, DSC = 6;
    localparam int DSUM = D1 + DH + D2;

    logic clk = 1'b0, rst = 1'b1;
    logic [3:0] mode_cfg = 4'd0;
    logic ms_tick = 1'b0, sig_good = 1'b0, open_ok = 1'b0;
    logic [2:0] class_code = 3'd0;
    logic uv_flag = 1'b0, ov_flag = 1'b0, fault_pulse = 1'b0, disc_pulse = 1'b0;
    logic [1:0] probe_sel, led_code;
    logic cls_en, mark_en, gate_en;
    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pse_port_seq #(
        .DET_LO1_MS(D1), .DET_HI_MS(DH), .DET_LO2_MS(D2), .GAP_END_MS(GEP),
        .GAP_MID_MS(GMS), .CLS_MS(CLS), .MARK_MS(MRK), .PWRUP_MS(PWR),
        .DENY_MS(DNY), .RESTART_MS(RST_MS), .DISC_MS(DSC)
    ) dut_i (
        .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .ms_tick(ms_tick),
        .sig_good(sig_good), .open_ok(open_ok), .class_code(class_code),
        .uv_flag(uv_flag), .ov_flag(ov_flag), .fault_pulse(fault_pulse),
        .disc_pulse(disc_pulse), .probe_sel(probe_sel), .cls_en(cls_en),
        .mark_en(mark_en), .gate_en(gate_en), .led_code(led_code)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div == 2) ? 0 : div + 1;
            ms_tick = (div == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (ms_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic do_reset(input logic [3:0] m);
        @(negedge clk);
        rst = 1'b1;
        mode_cfg = m;
        repeat (3) @(negedge clk);
        chk_eq("R1 gate in reset", gate_en, 0);
        chk_eq("R1 probe in reset", probe_sel, 0);
        chk_eq("R1 led in reset", led_code, 0);
        chk_eq("R1 cls in reset", cls_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 probe low after release", probe_sel, 1);
    endtask

    task automatic pulse_fault();
        fault_pulse = 1'b1; @(negedge clk); fault_pulse = 1'b0;
    endtask

    task automatic pulse_disc();
        disc_pulse = 1'b1; @(negedge clk); disc_pulse = 1'b0;
    endtask

    // Endpoint, auto restart, full budget with classification
    task automatic t_two_event_auto();
        sig_good = 1'b0; class_code = 3'd0;
        do_reset(4'b1111);
        wait_ticks(D1 - 1); chk_eq("R2 low step held", probe_sel, 1);
        wait_ticks(1);      chk_eq("R2 high step", probe_sel, 2);
        wait_ticks(DH);     chk_eq("R2 second low step", probe_sel, 1);
        wait_ticks(D2);     chk_eq("R3 probe off after bad signature", probe_sel, 0);
        chk_eq("R3 slow blink in gap", led_code, 1);
        wait_ticks(GEP - 1); chk_eq("R3 endpoint gap held", probe_sel, 0);
        wait_ticks(1);       chk_eq("R3 endpoint retry", probe_sel, 1);
        sig_good = 1'b1;
        wait_ticks(DSUM);   chk_eq("R4 first class pulse", cls_en, 1);
        chk_eq("R4 no mark in first pulse", mark_en, 0);
        wait_ticks(CLS);    chk_eq("R4 mark pulse", mark_en, 1);
        chk_eq("R4 class off during mark", cls_en, 0);
        wait_ticks(MRK);    chk_eq("R4 second class pulse", cls_en, 1);
        class_code = 3'd4;
        wait_ticks(CLS);    chk_eq("R4 gate on after class 4", gate_en, 1);
        chk_eq("R4 steady led", led_code, 2);
        pulse_disc();       chk_eq("R7 disconnect ignored in power-up", gate_en, 1);
        wait_ticks(PWR + 1);
        pulse_fault();      chk_eq("R8 gate off on fault", gate_en, 0);
        chk_eq("R8 fast blink", led_code, 3);
        wait_ticks(RST_MS - 1); chk_eq("R8 still waiting", probe_sel, 0);
        wait_ticks(1);          chk_eq("R8 auto restart probes", probe_sel, 1);
    endtask

    // Midspan, auto restart, full budget: fallback to one event
    task automatic t_fallback_disc();
        sig_good = 1'b0; class_code = 3'd2;
        do_reset(4'b0111);
        wait_ticks(DSUM);    chk_eq("R3 midspan gap starts", probe_sel, 0);
        wait_ticks(GMS - 1); chk_eq("R3 midspan gap held", probe_sel, 0);
        wait_ticks(1);       chk_eq("R3 midspan retry", probe_sel, 1);
        sig_good = 1'b1;
        wait_ticks(DSUM + CLS + MRK + CLS);
        chk_eq("R5 one-event pulse after class 2", cls_en, 1);
        chk_eq("R5 no gate yet", gate_en, 0);
        chk_eq("R5 no mark in fallback", mark_en, 0);
        wait_ticks(CLS);    chk_eq("R5 class 2 granted", gate_en, 1);
        wait_ticks(PWR);
        pulse_disc();       chk_eq("R10 gate off on disconnect", gate_en, 0);
        chk_eq("R10 led off", led_code, 0);
        wait_ticks(DSC - 1); chk_eq("R10 wait held", probe_sel, 0);
        wait_ticks(1);       chk_eq("R10 probing resumes", probe_sel, 1);
    endtask

    // Endpoint, latch-off, low budget with classification
    task automatic t_deny_latch();
        sig_good = 1'b1; class_code = 3'd3;
        do_reset(4'b1001);
        wait_ticks(DSUM);   chk_eq("R5 single pulse at low budget", cls_en, 1);
        wait_ticks(CLS);    chk_eq("R6 class 3 denied", led_code, 3);
        chk_eq("R6 gate off on denial", gate_en, 0);
        wait_ticks(DNY - 1); chk_eq("R6 denial blink held", led_code, 3);
        wait_ticks(1);       chk_eq("R6 probe after denial in latch-off", probe_sel, 1);
        class_code = 3'd7;
        wait_ticks(DSUM + CLS); chk_eq("R6 code 7 denied", led_code, 3);
        wait_ticks(DNY);        chk_eq("R6 probe after code 7", probe_sel, 1);
        class_code = 3'd1;
        wait_ticks(DSUM + CLS); chk_eq("R5 class 1 granted at low budget", gate_en, 1);
        wait_ticks(PWR);
        pulse_fault();
        wait_ticks(RST_MS + DNY);
        chk_eq("R9 latch-off keeps blinking", led_code, 3);
        chk_eq("R9 no probe before open", probe_sel, 0);
        open_ok = 1'b1; @(negedge clk); open_ok = 1'b0;
        chk_eq("R9 probe after open circuit", probe_sel, 1);
    endtask

    // Endpoint, auto restart, no classification; mode change and supply faults
    task automatic t_noclass_supply();
        sig_good = 1'b1; class_code = 3'd0;
        do_reset(4'b1100);
        mode_cfg = 4'b0001;
        wait_ticks(DSUM);   chk_eq("R12 gate on without classification", gate_en, 1);
        chk_eq("R12 no class pulse", cls_en, 0);
        wait_ticks(PWR);
        uv_flag = 1'b1; @(negedge clk);
        chk_eq("R11 gate off on undervoltage", gate_en, 0);
        chk_eq("R11 fast blink on undervoltage", led_code, 3);
        wait_ticks(RST_MS + 3); chk_eq("R11 error held while low supply", probe_sel, 0);
        uv_flag = 1'b0;
        wait_ticks(RST_MS - 1); chk_eq("R11 error timer after recovery", probe_sel, 0);
        wait_ticks(1);          chk_eq("R13 latched auto restart kept", probe_sel, 1);
        ov_flag = 1'b1; @(negedge clk);
        chk_eq("R11 overvoltage stops probe", probe_sel, 0);
        chk_eq("R11 overvoltage blink", led_code, 3);
        ov_flag = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        t_two_event_auto();
        t_fallback_disc();
        t_deny_latch();
        t_noclass_supply();
        report();
    end
endmodule